// File: doc/BRIEF.md
# Link-Up Stability Qualifier

This block sits between the raw link-status indication from a physical-layer device and the rest of a network controller. A link is reported as up only after the raw indication has stayed good, without a single drop, for a qualification period. Software picks that period with a 3-bit code, and the code selects one of eight durations between zero and two seconds. Time is measured by counting a free-running microsecond strobe, `tick_us`. A prescaler turns those strobes into 500 µs units, and a unit counter compares the elapsed units with the duration the code selects.

The qualified flag `link_up` is a register. On every change of the flag, `link_chg` pulses high for one cycle, so an interrupt or event path can pick up transitions without keeping its own copy of the flag. Going down is never qualified: the first cycle with the raw indication low clears the flag at the next edge.

Top module: `lsq_link_qualifier`

## Requirements
- R1: In reset and on the first edge after reset, `link_up` and `link_chg` are 0. The selected period code is 2.
- R2: A period code selects a duration in units of `UNIT_TICKS` strobes of `tick_us`, as follows: 0→0, 1→1, 2→2, 3→128, 4→512, 5→1024, 6→2000, 7→4000. With the default `UNIT_TICKS` of 500, these are 0, 500 µs, 1 ms, 64 ms, 256 ms, 512 ms, 1 s and 2 s.
- R3: With a nonzero duration of N units, `link_up` is set at the clock edge that ends the cycle carrying the (N·UNIT_TICKS)-th `tick_us` strobe seen while `raw_link` has been continuously high. Cycles without a strobe do not advance the count.
- R4: With code 0, `link_up` goes high at the first edge at which `raw_link` is sampled high.
- R5: If `raw_link` is low for any cycle while the link is qualifying, the count restarts from zero. Qualification then needs the full duration again.
- R6: If `raw_link` is low while `link_up` is 1, `link_up` is 0 after the next edge.
- R7: A write (`period_wr`=1) of a code that differs from the current one discards any qualification in progress, and the strobe in that cycle is not counted. The new code applies from the next cycle. A write of the same code, or any write while the link is up, does not change `link_up`.
- R8: `link_chg` is 1 for exactly the cycle that follows each edge at which `link_up` changes, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_link | input | 1 | Unfiltered link-good indication |
| tick_us | input | 1 | One-cycle strobe once per microsecond |
| period_wr | input | 1 | Loads `period_code` into the period selection |
| period_code | input | 3 | Qualification period code |
| link_up | output | 1 | Qualified link state |
| link_chg | output | 1 | One-cycle pulse on each change of `link_up` |

## Verification
The bench runs with a small `UNIT_TICKS` so that even the two-second code finishes in a few thousand cycles. For every code, it measures the number of cycles from the rise of `raw_link` to the rise of `link_up` with a strobe in every cycle; this separates an off-by-one in the prescaler from one in the unit counter or the code table. Directed cases cover a one-cycle dropout mid-qualification, a switch to a shorter code, a write of the same code, and a drop while the link is up. Constrained random traffic then mixes long and short runs of good status, sparse and dense strobes, and occasional code writes. Every cycle of this traffic is compared with a model that counts raw strobes, not units.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  localparam int unsigned CODE_W    = 3;
  localparam int unsigned MAX_UNITS = 4000;
  localparam int unsigned UNIT_W    = $clog2(MAX_UNITS + 1);
  localparam logic [CODE_W-1:0] RESET_CODE = 3'd2;

  typedef enum logic [1:0] {
    LS_DOWN = 2'd0,
    LS_QUAL = 2'd1,
    LS_UP   = 2'd2
  } lstate_e;

  // duration of each code in 500 us units
  function automatic logic [UNIT_W-1:0] code_units(input logic [CODE_W-1:0] c);
    case (c)
      3'd0:    code_units = UNIT_W'(0);
      3'd1:    code_units = UNIT_W'(1);
      3'd2:    code_units = UNIT_W'(2);
      3'd3:    code_units = UNIT_W'(128);
      3'd4:    code_units = UNIT_W'(512);
      3'd5:    code_units = UNIT_W'(1024);
      3'd6:    code_units = UNIT_W'(2000);
      default: code_units = UNIT_W'(4000);
    endcase
  endfunction
endpackage

// File: rtl/lsq_period_dec.sv
module lsq_period_dec
  import lsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CODE_W-1:0] code,
  output logic [UNIT_W-1:0] units,
  output logic              zero_period,
  output logic              restart
);
  logic [CODE_W-1:0] sel_q;
  logic [UNIT_W-1:0] units_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= RESET_CODE;
      units_q <= code_units(RESET_CODE);
    end else if (wr) begin
      sel_q   <= code;
      units_q <= code_units(code);
    end
  end

  assign units       = units_q;
  assign zero_period = (units_q == '0);
  assign restart     = wr && (code != sel_q);

  AST_UNITS_TRACK_SEL: assert property (@(posedge clk) disable iff (rst)
    (wr && !rst) |=> (units == code_units($past(code)))); // R2
endmodule

// File: rtl/lsq_prescaler.sv
module lsq_prescaler #(
  parameter int unsigned UNIT_TICKS = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic unit
);
  generate
    if (UNIT_TICKS <= 1) begin : g_direct
      assign unit = step;
    end else begin : g_count
      localparam int unsigned PW = $clog2(UNIT_TICKS);
      localparam logic [PW-1:0] LAST = PW'(UNIT_TICKS - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk) begin
        if (rst || clr)  pre_q <= '0;
        else if (step)   pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
      end

      assign unit = step && (pre_q == LAST);

      AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        pre_q <= LAST); // R3
      AST_PRE_HOLDS_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        (!step && !clr) |=> $stable(pre_q)); // R3
    end
  endgenerate
endmodule

// File: rtl/lsq_stab_count.sv
module lsq_stab_count
  import lsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              unit,
  input  logic [UNIT_W-1:0] target,
  output logic              done
);
  logic [UNIT_W-1:0] cnt_q;

  assign done = unit && (target != '0) && (cnt_q == target - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (unit)   cnt_q <= done ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_UNDER_TARGET: assert property (@(posedge clk) disable iff (rst)
    (target != '0) |-> (cnt_q < target)); // R3
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/lsq_link_qualifier.sv
module lsq_link_qualifier
  import lsq_pkg::*;
#(
  parameter int unsigned UNIT_TICKS = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raw_link,
  input  logic              tick_us,
  input  logic              period_wr,
  input  logic [CODE_W-1:0] period_code,
  output logic              link_up,
  output logic              link_chg
);
  logic [UNIT_W-1:0] units;
  logic              zero_period, restart, cnt_clr, step, unit, done;
  lstate_e           state_q, state_d;

  lsq_period_dec u_dec (
    .clk(clk), .rst(rst), .wr(period_wr), .code(period_code),
    .units(units), .zero_period(zero_period), .restart(restart)
  );

  assign cnt_clr = !raw_link || restart || (state_q == LS_UP);
  assign step    = tick_us && !cnt_clr;

  lsq_prescaler #(.UNIT_TICKS(UNIT_TICKS)) u_pre (
    .clk(clk), .rst(rst), .clr(cnt_clr), .step(step), .unit(unit)
  );

  lsq_stab_count u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .unit(unit), .target(units), .done(done)
  );

  always_comb begin
    if (!raw_link)               state_d = LS_DOWN;
    else if (state_q == LS_UP)   state_d = LS_UP;
    else if (restart)            state_d = LS_QUAL;
    else if (zero_period || done) state_d = LS_UP;
    else                         state_d = LS_QUAL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= LS_DOWN;
      link_up  <= 1'b0;
      link_chg <= 1'b0;
    end else begin
      state_q  <= state_d;
      link_up  <= (state_d == LS_UP);
      link_chg <= (state_d == LS_UP) != (state_q == LS_UP);
    end
  end

  AST_UP_NEEDS_RAW: assert property (@(posedge clk) disable iff (rst)
    !raw_link |=> !link_up); // R6
  AST_FALL_ONLY_ON_DROP: assert property (@(posedge clk) disable iff (rst)
    $fell(link_up) |-> !$past(raw_link)); // R6
  AST_CHG_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    (link_up != $past(link_up)) |-> link_chg); // R8
  AST_NO_CHG_STEADY: assert property (@(posedge clk) disable iff (rst)
    (link_up == $past(link_up)) |-> !link_chg); // R8
  AST_CODE0_FAST: assert property (@(posedge clk) disable iff (rst)
    (raw_link && zero_period && !restart) |=> link_up); // R4
  AST_RESTART_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (restart && !link_up) |=> !link_up); // R7
endmodule

// File: tb/sim_lsq_link_qualifier.sv
module sim_lsq_link_qualifier;
  localparam int unsigned P = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       raw_link = 1'b0, tick_us = 1'b0, period_wr = 1'b0;
  logic [2:0] period_code = 3'd0;
  logic       link_up, link_chg;

  int checks = 0, failures = 0;
  bit mup = 0, mprev = 0;
  int mt = 0;
  logic [2:0] msel = 3'd2;

  always #2 clk = ~clk;

  lsq_link_qualifier #(.UNIT_TICKS(P)) u0 (
    .clk(clk), .rst(rst), .raw_link(raw_link), .tick_us(tick_us),
    .period_wr(period_wr), .period_code(period_code),
    .link_up(link_up), .link_chg(link_chg)
  );

  function automatic int units_of(input logic [2:0] c);
    int t[8] = '{0, 1, 2, 128, 512, 1024, 2000, 4000};
    return t[c];
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, update model, sample at following negedge
  task automatic cyc(input bit r, input bit t, input bit w, input logic [2:0] c, input string tag);
    raw_link = r; tick_us = t; period_wr = w; period_code = c;
    mprev = mup;
    if (!r) begin mup = 0; mt = 0; end
    else if (mup) begin end
    else if (w && c != msel) mt = 0;
    else if (units_of(msel) == 0) mup = 1;
    else if (t) begin
      mt++;
      if (mt == units_of(msel) * P) begin mup = 1; mt = 0; end
    end
    if (w) msel = c;
    @(posedge clk); @(negedge clk);
    chk(tag, link_up, mup, "link_up");
    chk(tag, link_chg, mup != mprev, "link_chg");
  endtask

  // raw high with a strobe each cycle; returns cycles until link_up
  task automatic measure(input string tag, output int n);
    n = 0;
    do begin cyc(1, 1, 0, 3'd0, tag); n++; end while (!link_up && n < 9000);
  endtask

  task automatic expect_n(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s cycles actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1", link_up, 1'b0, "link_up in reset");
    chk("R1", link_chg, 1'b0, "link_chg in reset");
    rst = 1'b0;
    cyc(0, 1, 0, 3'd0, "R1");
    // default code 2 -> 2 units
    measure("R1", n); expect_n("R1 default period", n, 2 * P);
    cyc(0, 0, 0, 3'd0, "R6");
    // every code
    for (int c = 0; c < 8; c++) begin
      cyc(0, 0, 1, 3'(c), "R2");
      measure("R2", n);
      expect_n(c == 0 ? "R4 code0" : "R2 R3 period", n, c == 0 ? 1 : units_of(3'(c)) * P);
      cyc(0, 1, 0, 3'd0, "R6");
    end
    // strobes only every other cycle, code 1
    cyc(0, 0, 1, 3'd1, "R3");
    cyc(1, 1, 0, 3'd0, "R3"); cyc(1, 0, 0, 3'd0, "R3");
    chk("R3", link_up, 1'b0, "gap cycle no count");
    cyc(1, 1, 0, 3'd0, "R3");
    chk("R3", link_up, 1'b1, "up after 2nd strobe");
    cyc(0, 0, 0, 3'd0, "R6");
    // dropout mid-qualification, code 3
    cyc(0, 0, 1, 3'd3, "R5");
    repeat (100) cyc(1, 1, 0, 3'd0, "R5");
    cyc(0, 1, 0, 3'd0, "R5");
    measure("R5", n); expect_n("R5 restart after drop", n, 128 * P);
    // drop while up
    cyc(0, 1, 0, 3'd0, "R6");
    chk("R6", link_up, 1'b0, "cleared on drop");
    // code switch mid-qualification
    repeat (50) cyc(1, 1, 0, 3'd0, "R7");
    cyc(1, 1, 1, 3'd1, "R7");
    chk("R7", link_up, 1'b0, "restart cycle");
    measure("R7", n); expect_n("R7 new code", n, 1 * P);
    // write while up keeps link
    cyc(1, 1, 1, 3'd7, "R7");
    chk("R7", link_up, 1'b1, "write while up");
    cyc(0, 0, 0, 3'd0, "R7");
    // same-code write keeps counting
    cyc(0, 0, 1, 3'd1, "R7");
    cyc(1, 1, 0, 3'd0, "R7");
    cyc(1, 1, 1, 3'd1, "R7");
    chk("R7", link_up, 1'b1, "same-code write counted");
    // random
    for (int i = 0; i < 30000; i++) begin
      bit r, t, w;
      logic [2:0] c;
      r = ($urandom_range(0, 99) < (raw_link ? 98 : 10));
      t = ($urandom_range(0, 3) != 0);
      w = ($urandom_range(0, 299) == 0);
      c = 3'($urandom_range(0, 3));
      cyc(r, t, w, c, "R8");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule